// File: doc/BRIEF.md
# NAND Flash Page-Program Engine

This block is a synthesizable device-side model of the program path of a NAND flash die. A host writes command, address and data bytes over a strobed byte bus. One qualifier marks a byte as a command and another marks it as an address. A byte with neither qualifier is data. The data fills a 528-byte page staging register, which has a 512-byte main region followed by a 16-byte spare region. A confirm command then commits the staged page into a small on-chip cell array during a busy period whose length is a parameter.

Programming only clears bits. A verify step then flags any cell bit that was loaded as 0 but still reads 1. Each page has one counter per region for partial programs since the last erase, and a program that would go past the limit of that region is refused and reported as a failure. A ready/busy output and a status byte report progress and the result. A reset command aborts a program that is in progress. Test hooks can erase a page, force one bit position to stay at 1 during programming, and read any array byte directly.

Top module: `nand_prog_engine`

## Requirements
- R1: Command 80h opens a load. It is followed by three address bytes: the column low byte, then the column high bits in bits 1:0, then the page index. After that, each data byte is written into the page register at the current column and the column increments. Data bytes at columns 528 and above are discarded and do not wrap.
- R2: Command 80h presets every page-register byte to FFh, so array bytes that are not loaded keep their stored value when the page is programmed.
- R3: Command 10h sent after the three address bytes starts a program, and `rdy` stays low for exactly PROG_CYCLES cycles. A 10h sent without a completed load is ignored: `rdy` stays high and the array does not change.
- R4: While `rdy` is low during a program, only 70h and FFh take effect. Any other command, address byte or data byte is dropped.
- R5: The status byte has bit 6 equal to `rdy`, bit 0 equal to the result of the last program (1 = fail), and every other bit 0.
- R6: A program writes the bitwise AND of the stored byte and the loaded byte, so a loaded 1 over a stored 0 leaves the 0 in place and does not count as a failure.
- R7: The fail bit is set when some bit loaded as 0 still reads 1 after the program. A bit held at 1 by `fault_en`/`fault_bit` produces this failure. The fail bit changes only when a program ends or on reset.
- R8: Without an erase in between, a page accepts at most 2 programs that touch its main region (columns 0–511) and at most 3 that touch its spare region (columns 512–527). A further attempt sets the fail bit and leaves the cells unchanged.
- R9: After 70h, every `re` strobe loads the status byte onto `dout` on the next clock edge. This continues until 80h or FFh is written. Commands that are ignored do not end it, and outside this mode `dout` reads 00h.
- R10: FFh aborts any program in progress and leaves the array untouched. It also presets the page register to FFh and clears the fail bit. `rdy` is low for one cycle and then high again.
- R11: An `erase_req` pulse sets the selected page to all FFh and clears both of its partial-program counters.
- R12: `peek_data` combinationally returns the array byte at `peek_page`/`peek_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the array powers up erased |
| we | input | 1 | Byte write strobe |
| cle | input | 1 | Marks the written byte as a command |
| ale | input | 1 | Marks the written byte as an address |
| din | input | 8 | Command, address or data byte |
| re | input | 1 | Read strobe |
| dout | output | 8 | Read data, status byte while in status mode |
| rdy | output | 1 | High when ready, low while busy |
| fault_en | input | 1 | Enables a stuck-at-1 bit during programming |
| fault_bit | input | 3 | Bit position held at 1 |
| erase_req | input | 1 | Erase-page test hook |
| erase_page | input | log2(NUM_PAGES) | Page to erase |
| peek_page | input | log2(NUM_PAGES) | Page for direct array read |
| peek_col | input | log2(PAGE_BYTES) | Column for direct array read |
| peek_data | output | 8 | Array byte at peek address |

## Verification
On every cycle, the assertions check the handshake rules that involve only a few cycles. A confirm after a load must drop `rdy`, and a lone confirm must leave it high. FFh must pull `rdy` low for a single cycle. The status byte read back must match `rdy`, and the fail bit must not move while the block stays ready. Other properties depend on array contents and program history, and only the bench scenarios can show them. These include the exact busy length, AND-only programming, skipped columns, the per-region partial-program limits, the effect of the stuck bit on verify, commands dropped during busy, abort without a write, and the erase hook restoring the program budget.

// File: rtl/nand_prog_engine.sv
module nand_prog_engine #(
  parameter int PAGE_BYTES  = 528,
  parameter int MAIN_BYTES  = 512,
  parameter int NUM_PAGES   = 4,
  parameter int PROG_CYCLES = 20,
  parameter int MAIN_LIMIT  = 2,
  parameter int SPARE_LIMIT = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic                          cle,
  input  logic                          ale,
  input  logic [7:0]                    din,
  input  logic                          re,
  output logic [7:0]                    dout,
  output logic                          rdy,
  input  logic                          fault_en,
  input  logic [2:0]                    fault_bit,
  input  logic                          erase_req,
  input  logic [$clog2(NUM_PAGES)-1:0]  erase_page,
  input  logic [$clog2(NUM_PAGES)-1:0]  peek_page,
  input  logic [$clog2(PAGE_BYTES)-1:0] peek_col,
  output logic [7:0]                    peek_data
);
  localparam int PW   = $clog2(NUM_PAGES);
  localparam int CW   = $clog2(PAGE_BYTES);
  localparam int BW   = $clog2(PROG_CYCLES + 1);
  localparam int LMAX = (MAIN_LIMIT > SPARE_LIMIT) ? MAIN_LIMIT : SPARE_LIMIT;
  localparam int NW   = $clog2(LMAX + 1);
  localparam int CELLS = NUM_PAGES * PAGE_BYTES;
  localparam logic [CW-1:0] COL_END  = CW'(PAGE_BYTES);
  localparam logic [CW-1:0] COL_MAIN = CW'(MAIN_BYTES);
  localparam logic [BW-1:0] BUSY_TOP = BW'(PROG_CYCLES - 1);
  localparam logic [NW-1:0] LIM_M    = NW'(MAIN_LIMIT);
  localparam logic [NW-1:0] LIM_S    = NW'(SPARE_LIMIT);
  localparam logic [7:0] OP_LOAD = 8'h80, OP_GO = 8'h10, OP_STAT = 8'h70, OP_RST = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_BUSY, S_RST} state_t;

  state_t          state;
  logic [1:0]      acnt;
  logic [7:0]      col_lo;
  logic [CW-1:0]   col;
  logic [PW-1:0]   page_q;
  logic            t_main, t_spare, blocked, fail, smode;
  logic [BW-1:0]   bcnt;
  logic [NW-1:0]   mcnt [NUM_PAGES];
  logic [NW-1:0]   scnt [NUM_PAGES];
  logic [7:0]      pr   [PAGE_BYTES];
  logic [7:0]      arr  [CELLS];
  logic [7:0]      nxt  [PAGE_BYTES];
  logic            vfail;
  logic [7:0]      stuck;
  logic [15:0]     col_full;
  logic            over, load_phase, rst_phase;

  wire wr_cmd  = we & cle;
  wire wr_addr = we & ale & ~cle;
  wire wr_data = we & ~cle & ~ale;
  wire commit  = (state == S_BUSY) && (bcnt == '0) && !blocked;

  assign rdy        = (state != S_BUSY) && (state != S_RST);
  assign load_phase = (state == S_DATA);
  assign rst_phase  = (state == S_RST);
  assign col_full   = {din, col_lo};
  assign stuck      = fault_en ? (8'h01 << fault_bit) : 8'h00;
  assign over       = (t_main && mcnt[page_q] >= LIM_M) || (t_spare && scnt[page_q] >= LIM_S);
  assign peek_data  = arr[int'(peek_page) * PAGE_BYTES + int'(peek_col)];

  always_comb begin
    vfail = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) begin
      nxt[i] = arr[int'(page_q) * PAGE_BYTES + i] & (pr[i] | stuck);
      if ((~pr[i] & nxt[i]) != 8'h00) vfail = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) arr[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) arr[int'(page_q) * PAGE_BYTES + i] <= nxt[i];
    end else if (erase_req && state != S_BUSY) begin
      for (int i = 0; i < PAGE_BYTES; i++) arr[int'(erase_page) * PAGE_BYTES + i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; acnt <= '0; col_lo <= '0; col <= '0; page_q <= '0;
      t_main <= 1'b0; t_spare <= 1'b0; blocked <= 1'b0; fail <= 1'b0; smode <= 1'b0;
      bcnt <= '0; dout <= '0;
      for (int p = 0; p < NUM_PAGES; p++) begin
        mcnt[p] <= '0;
        scnt[p] <= '0;
      end
      for (int i = 0; i < PAGE_BYTES; i++) pr[i] <= 8'hFF;
    end else begin
      if (re) dout <= smode ? {1'b0, rdy, 5'b0, fail} : 8'h00;
      if (wr_cmd && din == OP_RST) begin
        state <= S_RST; fail <= 1'b0; smode <= 1'b0; blocked <= 1'b0;
        for (int i = 0; i < PAGE_BYTES; i++) pr[i] <= 8'hFF;
      end else begin
        if (wr_cmd && din == OP_STAT) smode <= 1'b1;
        case (state)
          S_BUSY: begin
            if (bcnt == '0) begin
              state <= S_IDLE;
              fail  <= blocked | vfail;
            end else begin
              bcnt <= bcnt - 1'b1;
            end
          end
          S_RST: state <= S_IDLE;
          default: begin
            if (wr_cmd && din == OP_LOAD) begin
              state <= S_ADDR; acnt <= '0; smode <= 1'b0;
              t_main <= 1'b0; t_spare <= 1'b0;
              for (int i = 0; i < PAGE_BYTES; i++) pr[i] <= 8'hFF;
            end else if (wr_cmd && din == OP_GO && state == S_DATA) begin
              state   <= S_BUSY;
              bcnt    <= BUSY_TOP;
              blocked <= over;
              if (!over && t_main)  mcnt[page_q] <= mcnt[page_q] + 1'b1;
              if (!over && t_spare) scnt[page_q] <= scnt[page_q] + 1'b1;
            end else if (wr_addr && state == S_ADDR) begin
              acnt <= acnt + 1'b1;
              case (acnt)
                2'd0:    col_lo <= din;
                2'd1:    col    <= col_full[CW-1:0];
                default: begin
                  page_q <= din[PW-1:0];
                  state  <= S_DATA;
                end
              endcase
            end else if (wr_data && state == S_DATA && col < COL_END) begin
              pr[col] <= din;
              col     <= col + 1'b1;
              if (col < COL_MAIN) t_main  <= 1'b1;
              else                t_spare <= 1'b1;
            end
          end
        endcase
      end
      if (erase_req && state != S_BUSY) begin
        mcnt[erase_page] <= '0;
        scnt[erase_page] <= '0;
      end
    end
  end
endmodule

module nand_prog_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       we,
  input logic       cle,
  input logic [7:0] din,
  input logic       re,
  input logic       rdy,
  input logic [7:0] dout,
  input logic       load_phase,
  input logic       rst_phase,
  input logic       fail,
  input logic       smode
);
  wire go_cmd  = we && cle && din == 8'h10;
  wire rst_cmd = we && cle && din == 8'hFF;

  p_confirm_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cmd && load_phase) |=> !rdy);
  p_lone_confirm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cmd && !load_phase && rdy) |=> rdy);
  p_status_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (re && smode) |=> (dout[6] == $past(rdy)) && (dout[7] == 1'b0) && (dout[5:1] == 5'b0));
  p_fail_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $past(rdy)) |-> $stable(fail));
  p_plain_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (re && !smode) |=> dout == 8'h00);
  p_reset_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> !rdy);
  p_reset_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_phase && !rst_cmd) |=> rdy);
endmodule

bind nand_prog_engine nand_prog_checks u_checks (
  .clk(clk), .rst_n(rst_n), .we(we), .cle(cle), .din(din), .re(re), .rdy(rdy),
  .dout(dout), .load_phase(load_phase), .rst_phase(rst_phase), .fail(fail), .smode(smode)
);

// File: tb/tb_nand_prog_engine.sv
module tb_nand_prog_engine;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYCLES = 20;

  logic clk = 0, rst_n = 0, we = 0, cle = 0, ale = 0, re = 0;
  logic [7:0] din = 0;
  logic fault_en = 0, erase_req = 0;
  logic [2:0] fault_bit = 0;
  logic [1:0] erase_page = 0, peek_page = 0;
  logic [9:0] peek_col = 0;
  logic [7:0] dout, peek_data;
  logic rdy;

  int checks = 0, fails = 0;
  bit done = 0;
  logic re_d = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  nand_prog_engine #(.PROG_CYCLES(PROG_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .we(we), .cle(cle), .ale(ale), .din(din), .re(re),
    .dout(dout), .rdy(rdy), .fault_en(fault_en), .fault_bit(fault_bit),
    .erase_req(erase_req), .erase_page(erase_page), .peek_page(peek_page),
    .peek_col(peek_col), .peek_data(peek_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares dout after every read strobe
  always @(posedge clk) re_d <= re;
  always @(negedge clk) begin
    if (re_d && exp_q.size() > 0) chk(tag_q.pop_front(), dout, exp_q.pop_front());
  end

  task automatic drive(logic c, logic a, logic [7:0] d);
    we = 1; cle = c; ale = a; din = d;
    @(posedge clk); @(negedge clk);
    we = 0; cle = 0; ale = 0;
  endtask
  task automatic cmd(logic [7:0] d);  drive(1, 0, d); endtask
  task automatic adr(logic [7:0] d);  drive(0, 1, d); endtask
  task automatic dat(logic [7:0] d);  drive(0, 0, d); endtask
  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic load(int pg, int c);
    cmd(8'h80); adr(8'(c)); adr(8'(c >> 8)); adr(8'(pg));
  endtask

  task automatic rd(logic [7:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    re = 1; tick(); re = 0;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rdy && n < 1000) begin n++; tick(); end
  endtask

  task automatic peek(int pg, int c, logic [7:0] e, string tag);
    peek_page = 2'(pg); peek_col = 10'(c); #1;
    chk(tag, peek_data, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset rdy", rdy, 1);
    peek(0, 0, 8'hFF, "R12 erased at reset");
    cmd(8'h70);
    rd(8'h40, "R5 status ready pass");
    rd(8'h40, "R9 repeated status read");

    load(0, 5); dat(8'hA5); dat(8'h3C);
    rd(8'h00, "R9 plain read after 80h");
    cmd(8'h10);
    wait_rdy(n);
    chk("R3 busy length", n, PROG_CYCLES);
    cmd(8'h70); rd(8'h40, "R7 pass status");
    peek(0, 5, 8'hA5, "R1 first byte at column");
    peek(0, 6, 8'h3C, "R1 column increments");
    peek(0, 4, 8'hFF, "R2 byte before load");
    peek(0, 7, 8'hFF, "R2 byte after load");

    load(0, 5); dat(8'hFF); dat(8'h00); cmd(8'h10); wait_rdy(n);
    cmd(8'h70); rd(8'h40, "R6 one over zero passes");
    peek(0, 5, 8'hA5, "R6 zero bits kept");
    peek(0, 6, 8'h00, "R6 bits cleared");

    load(0, 10); dat(8'h00); cmd(8'h10); wait_rdy(n);
    cmd(8'h70); rd(8'h41, "R8 third main program fails");
    peek(0, 10, 8'hFF, "R8 refused program leaves cells");

    cmd(8'h10);
    chk("R3 lone confirm keeps rdy", rdy, 1);
    peek(0, 10, 8'hFF, "R3 lone confirm no write");
    rd(8'h41, "R9 status mode survives ignored cmd");

    for (int k = 0; k < 3; k++) begin
      load(1, 512 + k); dat(8'h00); cmd(8'h10); wait_rdy(n);
      cmd(8'h70); rd(8'h40, "R8 spare program within limit");
    end
    load(1, 515); dat(8'h00); cmd(8'h10); wait_rdy(n);
    cmd(8'h70); rd(8'h41, "R8 fourth spare program fails");
    peek(1, 515, 8'hFF, "R8 spare cell untouched");
    peek(1, 512, 8'h00, "R8 earlier spare program kept");

    cmd(8'hFF);
    chk("R10 rdy low after reset cmd", rdy, 0);
    tick();
    chk("R10 rdy back", rdy, 1);
    cmd(8'h70); rd(8'h40, "R10 fail cleared");

    load(2, 0); dat(8'h0F); cmd(8'h10);
    cmd(8'h70);
    rd(8'h00, "R5 busy status bit6 low");
    cmd(8'h80); dat(8'h00);
    wait_rdy(n);
    rd(8'h40, "R4 status mode kept, 80h dropped");
    peek(2, 0, 8'h0F, "R4 program completed");
    peek(2, 1, 8'hFF, "R4 data during busy dropped");

    fault_en = 1; fault_bit = 3'd3;
    load(3, 0); dat(8'h00); cmd(8'h10); wait_rdy(n);
    fault_en = 0;
    cmd(8'h70); rd(8'h41, "R7 stuck bit fails verify");
    peek(3, 0, 8'h08, "R7 stuck bit stays one");

    load(3, 2); dat(8'h00); cmd(8'h10);
    tick(); tick(); tick();
    cmd(8'hFF);
    chk("R10 abort rdy low", rdy, 0);
    tick();
    chk("R10 abort rdy high", rdy, 1);
    peek(3, 2, 8'hFF, "R10 aborted program no write");

    erase_page = 2'd0; erase_req = 1; tick(); erase_req = 0;
    peek(0, 5, 8'hFF, "R11 erased byte");
    peek(0, 6, 8'hFF, "R11 erased byte 2");
    load(0, 6); dat(8'h00); cmd(8'h10); wait_rdy(n);
    cmd(8'h70); rd(8'h40, "R11 counters cleared");
    peek(0, 6, 8'h00, "R11 program after erase");

    load(2, 527); dat(8'h11); dat(8'h22); cmd(8'h10); wait_rdy(n);
    peek(2, 527, 8'h11, "R1 last column loaded");
    peek(2, 0, 8'h0F, "R1 no wrap past last column");

    tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule